// File: doc/BRIEF.md
# Masked Frame Address Recognizer

This block decides whether an incoming HDLC/LAPD frame is addressed to this station by looking at the frame's first address octet only. It checks the octet against two programmable station addresses and one fixed group address. A per-bit mask register can exclude selected bit positions from the two programmable comparisons, typically the command/response bit. The group comparison always checks every bit, whatever the mask holds.

Software sets the mask and the two addresses through a small write port. The framing logic pulses a frame-start input at the beginning of each frame. It then strobes the first address octet. One cycle after the strobe, the block presents a registered accept/reject verdict together with the octet's extension bit. Downstream logic uses the extension bit to tell whether a second address octet follows. The verdict stays in place until the next frame start.

Top module: `frame_addr_match`

## Requirements
- R1: After reset the mask and both programmable addresses are 0x00, and `result_valid_o`, `match_o`, `reject_o` and `ea_o` are all 0.
- R2: A write with `reg_we_i`=1 loads `reg_wdata_i` into the register chosen by `reg_sel_i`: 0 selects the mask, 1 selects address 1, 2 selects address 2. Select code 3 changes nothing. A strobe in the same cycle as a write is compared against the values held before the write.
- R3: The octet matches address 1 when every bit position whose mask bit is 0 agrees. A mask bit of 1 removes that position from the comparison.
- R4: The octet matches address 2 under the same masked rule, using the same mask.
- R5: The octet matches the group address 0xFC only when all eight bits are equal. The mask has no effect on this comparison.
- R6: `match_o` is the OR of the three comparisons. `reject_o` is 1 exactly when `result_valid_o`=1 and `match_o`=0, so the two are never high together.
- R7: The verdict appears with `result_valid_o`=1 in the cycle after an accepted `first_i` strobe. A `frame_start_i` pulse without a strobe clears `result_valid_o`, `match_o`, `reject_o` and `ea_o` in the next cycle.
- R8: While `result_valid_o`=1, further `first_i` strobes without `frame_start_i` are ignored. The verdict and `ea_o` stay unchanged.
- R9: `ea_o` carries bit 0 of the captured octet (1 means a one-octet address, 0 means a second octet follows). Bit 1 is the command/response bit and is treated as any other bit.
- R10: When `frame_start_i` and `first_i` are high in the same cycle, the strobe is accepted and its verdict is shown in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Register select: 0 mask, 1 address 1, 2 address 2, 3 none |
| reg_wdata_i | input | 8 | Register write data |
| frame_start_i | input | 1 | Start of a new frame, clears the held verdict |
| first_i | input | 1 | Strobe marking the first address octet |
| octet_i | input | 8 | Received octet |
| result_valid_o | output | 1 | Verdict for the current frame is present |
| match_o | output | 1 | Frame accepted |
| reject_o | output | 1 | Frame rejected |
| ea_o | output | 1 | Extension bit of the captured octet |

## Verification
The comparisons are first tried with directed octets. One is equal to address 1 except in a masked position. Another is equal to the group address except for the command/response bit while that bit is masked; this separates the masked rule from the unmasked group rule. Other cases set a mask of all ones, or use octets that hit only address 2. Random register writes and octets follow, with octets biased towards near-copies of the programmed addresses and the group value, so that hits on each path and misses in unmasked bits both appear often. Directed sequences cover a write in the same cycle as the strobe, a second strobe while a verdict is held, and a strobe that coincides with frame start.

// File: rtl/far_pkg.sv
package far_pkg;
  typedef struct packed {
    logic match;
    logic ea;
  } far_verdict_t;
endpackage

// File: rtl/far_regs.sv
module far_regs #(
  parameter int unsigned W      = 8,
  parameter int unsigned N_PROG = 2,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [W-1:0]                 wdata_i,
  output logic [W-1:0]                 mask_o,
  output logic [N_PROG-1:0][W-1:0]     addr_o
);
  logic [W-1:0]             mask_q;
  logic [N_PROG-1:0][W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               mask_q <= '0;
    else if (we_i && sel_i == SEL_W'(0))       mask_q <= wdata_i;
  end

  for (genvar k = 0; k < N_PROG; k++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             addr_q[k] <= '0;
      else if (we_i && sel_i == SEL_W'(k + 1)) addr_q[k] <= wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign addr_o = addr_q;

  // R2: unused select codes leave every register untouched
  p_bad_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(sel_i) > N_PROG) |=> ($stable(mask_q) && $stable(addr_q)));
endmodule

// File: rtl/far_cmp.sv
module far_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] octet_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);
  logic [W-1:0] diff;
  assign diff  = (octet_i ^ ref_i) & ~mask_i;
  assign hit_o = (diff == '0);
endmodule

// File: rtl/far_hold.sv
module far_hold
  import far_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         first_i,
  input  far_verdict_t verdict_i,
  output logic         valid_o,
  output far_verdict_t verdict_o
);
  logic         valid_q;
  far_verdict_t verdict_q;
  logic         take;

  // a new strobe wins over frame start; a held verdict blocks repeats
  assign take = first_i && (!valid_q || start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
    end else if (take) begin
      valid_q   <= 1'b1;
      verdict_q <= verdict_i;
    end else if (start_i) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
    end
  end

  assign valid_o   = valid_q;
  assign verdict_o = verdict_q;

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_i && (!valid_o || start_i)) |=> valid_o);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !first_i) |=> (!valid_o && verdict_o == '0));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> (valid_o && $stable(verdict_o)));
  p_new_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && first_i) |=> (valid_o && verdict_o == $past(verdict_i)));
endmodule

// File: rtl/frame_addr_match.sv
module frame_addr_match
  import far_pkg::*;
#(
  parameter int unsigned       W          = 8,
  parameter int unsigned       N_PROG     = 2,
  parameter logic [W-1:0]      GROUP_ADDR = 8'hFC,
  localparam int unsigned      SEL_W      = $clog2(N_PROG + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [W-1:0]     reg_wdata_i,
  input  logic             frame_start_i,
  input  logic             first_i,
  input  logic [W-1:0]     octet_i,
  output logic             result_valid_o,
  output logic             match_o,
  output logic             reject_o,
  output logic             ea_o
);
  localparam int unsigned N_CMP = N_PROG + 1;

  logic [W-1:0]             mask;
  logic [N_PROG-1:0][W-1:0] addr;
  logic [N_CMP-1:0]         hits;
  far_verdict_t             verdict_d, verdict_q;
  logic                     valid;

  far_regs #(.W(W), .N_PROG(N_PROG), .SEL_W(SEL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask),
    .addr_o  (addr)
  );

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    if (k < N_PROG) begin : g_prog
      far_cmp #(.W(W)) u_cmp (
        .octet_i (octet_i),
        .ref_i   (addr[k]),
        .mask_i  (mask),
        .hit_o   (hits[k])
      );
    end else begin : g_group
      far_cmp #(.W(W)) u_cmp (
        .octet_i (octet_i),
        .ref_i   (GROUP_ADDR),
        .mask_i  ({W{1'b0}}),
        .hit_o   (hits[k])
      );
    end
  end

  assign verdict_d.match = |hits;
  assign verdict_d.ea    = octet_i[0];

  far_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (frame_start_i),
    .first_i   (first_i),
    .verdict_i (verdict_d),
    .valid_o   (valid),
    .verdict_o (verdict_q)
  );

  assign result_valid_o = valid;
  assign match_o        = verdict_q.match;
  assign ea_o           = verdict_q.ea;
  assign reject_o       = valid && !verdict_q.match;

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(match_o && reject_o));
  p_group_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_i && (!result_valid_o || frame_start_i) && octet_i == GROUP_ADDR)
    |=> match_o);
  p_ea_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_i && (!result_valid_o || frame_start_i)) |=> (ea_o == $past(octet_i[0])));
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> (!match_o && !reject_o && !ea_o));
endmodule

// File: tb/frame_addr_match_tb_top.sv
module frame_addr_match_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] wdata = '0;
  logic       fstart = 1'b0;
  logic       first = 1'b0;
  logic [7:0] octet = '0;
  logic       valid, match, reject, ea;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m_mask = '0, m_a1 = '0, m_a2 = '0;
  localparam logic [7:0] GRP = 8'hFC;

  always #2 clk = ~clk;

  frame_addr_match dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .frame_start_i(fstart), .first_i(first),
    .octet_i(octet), .result_valid_o(valid), .match_o(match),
    .reject_o(reject), .ea_o(ea)
  );

  function automatic bit exp_hit(input logic [7:0] o, input logic [7:0] m,
                                 input logic [7:0] a1, input logic [7:0] a2);
    bit h1, h2, hg;
    h1 = 1'b1; h2 = 1'b1;
    for (int b = 0; b < 8; b++) begin
      if (!m[b] && o[b] != a1[b]) h1 = 1'b0;
      if (!m[b] && o[b] != a2[b]) h2 = 1'b0;
    end
    hg = (o == GRP);
    return h1 | h2 | hg;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input bit v, input bit m, input bit e);
    chk({req, " valid"}, {7'b0, valid}, {7'b0, v});
    chk({req, " match"}, {7'b0, match}, {7'b0, m});
    chk({req, " reject"}, {7'b0, reject}, {7'b0, v & ~m});
    chk({req, " ea"}, {7'b0, ea}, {7'b0, e});
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (s)
      2'd0: m_mask = d;
      2'd1: m_a1 = d;
      2'd2: m_a2 = d;
      default: ;
    endcase
  endtask

  task automatic new_frame;
    @(negedge clk);
    fstart = 1'b1;
    @(negedge clk);
    fstart = 1'b0;
  endtask

  // strobe one octet and sample the verdict in the following cycle
  task automatic strobe(input logic [7:0] o);
    @(negedge clk);
    first = 1'b1; octet = o;
    @(negedge clk);
    first = 1'b0; octet = $urandom();
  endtask

  task automatic frame_check(input string req, input logic [7:0] o);
    new_frame();
    chk_out({req, " cleared R7"}, 1'b0, 1'b0, 1'b0);
    strobe(o);
    chk_out(req, 1'b1, exp_hit(o, m_mask, m_a1, m_a2), o[0]);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk_out("R1 reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1 after release", 1'b0, 1'b0, 1'b0);
    // R1: reset registers are zero -> octet 0x00 matches address 1
    frame_check("R1 zero regs", 8'h00);
    frame_check("R3 miss", 8'h10);

    wr(2'd1, 8'h42); wr(2'd2, 8'h3B);
    frame_check("R3 exact a1", 8'h42);
    frame_check("R4 exact a2", 8'h3B);
    frame_check("R9 ea one-octet", 8'h3B);
    wr(2'd0, 8'h02);
    frame_check("R3 cr masked a1", 8'h40);
    frame_check("R4 cr masked a2", 8'h39);
    frame_check("R3 unmasked diff", 8'h43);
    // R5: group ignores mask -> 0xFE misses even with C/R masked
    frame_check("R5 group exact", 8'hFC);
    frame_check("R5 group cr masked miss", 8'hFE);
    wr(2'd0, 8'hFF);
    frame_check("R3 mask all", 8'h77);
    // R2: code 3 writes nothing
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h77);
    frame_check("R2 sel3 ignored", 8'h77);
    frame_check("R2 regs intact", 8'h42);

    // R2: same-cycle write uses old address
    new_frame();
    @(negedge clk);
    we = 1'b1; sel = 2'd1; wdata = 8'h50; first = 1'b1; octet = 8'h50;
    @(negedge clk);
    we = 1'b0; first = 1'b0;
    chk_out("R2 same-cycle old value", 1'b1, 1'b0, 1'b0);
    m_a1 = 8'h50;
    frame_check("R2 new value used", 8'h50);

    // R8: second strobe ignored while held
    new_frame();
    strobe(8'h50);
    strobe(8'h11);
    chk_out("R8 repeat strobe ignored", 1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk_out("R8 held", 1'b1, 1'b1, 1'b0);

    // R10: strobe with frame start is accepted
    @(negedge clk);
    fstart = 1'b1; first = 1'b1; octet = 8'h11;
    @(negedge clk);
    fstart = 1'b0; first = 1'b0;
    chk_out("R10 start+strobe", 1'b1, 1'b0, 1'b1);

    // R6 random mix
    for (int i = 0; i < 400; i++) begin
      int pick;
      logic [7:0] o;
      if ($urandom_range(3) == 0) wr(2'($urandom_range(3)), 8'($urandom()));
      pick = $urandom_range(4);
      case (pick)
        0: o = m_a1 ^ (8'($urandom()) & m_mask);
        1: o = m_a2 ^ (8'($urandom()) & m_mask);
        2: o = GRP ^ (8'(1) << $urandom_range(7)) & {8{$urandom_range(1) == 1}};
        3: o = m_a1 ^ (8'(1) << $urandom_range(7));
        default: o = 8'($urandom());
      endcase
      frame_check("R6 random", o);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule